// File: doc/BRIEF.md
# Reaction Timer with Best-Time Register

This block measures how fast a person reacts to a light and reports the result in milliseconds. A press of the start button lights the red LED and arms a fixed delay. When the delay runs out, the red LED goes dark and the green LED lights. A counter then advances once per millisecond tick until the react button is pressed. At that point the counter holds its value and both LEDs go dark.

If react is pressed while the red LED is still lit, the attempt counts as a false start. The time output shows the error code 0xFF and the machine returns to idle. A second register keeps the smallest valid time seen so far. That register can be cleared on its own, without touching the current result.

The block is a three-state Moore machine. The states are idle, wait and count, and the LEDs are decoded from the state register alone. All four buttons are active-low levels. They are assumed to be debounced and synchronous to the clock. The millisecond tick is a one-cycle enable pulse from an external divider, and both time values are 8-bit codes meant for two hex digits.

Top module: `rxn_timer`

## Requirements
- R1: After the chip reset `rst_ni` is released (two-stage synchronous release), both LEDs are off, `cur_time_o` is 0x00 and `best_time_o` is 0xFF.
- R2: A low level on `start_ni` in idle moves the machine to wait. On the next cycle `red_led_o`=1, `green_led_o`=0 and `cur_time_o`=0x00.
- R3: The machine stays in wait for exactly `WAIT_MS` cycles that have `ms_tick_i` high; cycles without a tick do not advance the delay. On the cycle after the last of those ticks, `green_led_o`=1, `red_led_o`=0 and `cur_time_o`=0x00.
- R4: In count, every cycle with `ms_tick_i` high raises `cur_time_o` by one, visible on the next cycle. Cycles without a tick leave it unchanged.
- R5: In count, `cur_time_o` saturates at 0xFE (all ones minus one), so a valid time never equals the error code.
- R6: A low level on `react_ni` in count returns the machine to idle on the next cycle with both LEDs off. A tick in that same cycle is not counted. The frozen value is held until the next start or restart.
- R7: A low level on `react_ni` in wait sets `cur_time_o` to 0xFF on the next cycle and returns the machine to idle with both LEDs off.
- R8: A low level on `restart_ni` in any state gives idle and `cur_time_o`=0x00 on the next cycle, and leaves `best_time_o` unchanged. It overrides start and react in the same cycle.
- R9: A low level on `clear_ni` loads 0xFF into `best_time_o` on the next cycle. This overrides a capture in the same cycle.
- R10: `best_time_o` changes only when react freezes a count. It then takes the frozen value, on the next cycle, if that value is strictly smaller; a false-start 0xFF never lowers it.
- R11: `start_ni` has no effect in wait or count, and `react_ni` has no effect in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low chip reset, released synchronously |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| start_ni | input | 1 | Start button, low when pressed |
| react_ni | input | 1 | Reaction button, low when pressed |
| restart_ni | input | 1 | Game reset button, low when pressed |
| clear_ni | input | 1 | Best-time clear button, low when pressed |
| red_led_o | output | 1 | High in wait |
| green_led_o | output | 1 | High in count |
| cur_time_o | output | TIME_W | Current or frozen reaction time, 0xFF on false start |
| best_time_o | output | TIME_W | Smallest valid reaction time since clear |

## Verification
The LEDs decode the state register directly. A wrong state therefore shows one cycle after the press or tick that caused it, either as a wrong LED pair or as an LED that turns early or late. A fault in the wait delay counter shows only as green lighting after the wrong number of ticks, so the bench counts ticks exactly and checks the LEDs one tick before the transition as well as at it. A corrupt best-time register stays hidden until the next freeze or clear. For that reason captures are checked for faster, slower, zero, saturated and cleared-same-cycle results.

// File: rtl/rxn_pkg.sv
package rxn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2
  } rxn_state_e;
endpackage

// File: rtl/rxn_rst_sync.sv
module rxn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rxn_ctrl.sv
module rxn_ctrl
  import rxn_pkg::*;
#(
  parameter int unsigned WAIT_MS = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       react_i,
  input  logic       restart_i,
  output rxn_state_e state_o,
  output logic       arm_o,
  output logic       freeze_o,
  output logic       early_o
);
  localparam int unsigned WCNT_W = $clog2(WAIT_MS + 1);
  localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(WAIT_MS - 1);

  rxn_state_e        state_q, state_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              state_en, wcnt_en;

  always_comb begin
    state_d  = state_q;
    wcnt_d   = wcnt_q;
    arm_o    = 1'b0;
    freeze_o = 1'b0;
    early_o  = 1'b0;
    if (restart_i) begin
      state_d = ST_IDLE;
      wcnt_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_d = ST_WAIT;
            wcnt_d  = '0;
            arm_o   = 1'b1;
          end
        end
        ST_WAIT: begin
          if (react_i) begin
            state_d = ST_IDLE;
            early_o = 1'b1;
          end else if (tick_i) begin
            if (wcnt_q == WAIT_LAST) state_d = ST_COUNT;
            else                     wcnt_d  = wcnt_q + WCNT_W'(1);
          end
        end
        ST_COUNT: begin
          if (react_i) begin
            state_d  = ST_IDLE;
            freeze_o = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign state_en = (state_d != state_q);
  assign wcnt_en  = (wcnt_d != wcnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= ST_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  assign state_o = state_q;

  // R2
  arm_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !restart_i) |=> (state_q == ST_WAIT));
  // R3
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (32'(wcnt_q) < WAIT_MS));
  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !tick_i && !react_i && !restart_i)
      |=> (state_q == ST_WAIT && $stable(wcnt_q)));
  // R6
  freeze_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && react_i && !restart_i) |=> (state_q == ST_IDLE));
  // R8
  restart_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == ST_IDLE));
  // R11
  idle_react_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i && !restart_i) |=> (state_q == ST_IDLE));
  // R11
  count_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && !react_i && !restart_i) |=> (state_q == ST_COUNT));
endmodule

// File: rtl/rxn_time.sv
module rxn_time #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              arm_i,
  input  logic              early_i,
  input  logic              freeze_i,
  input  logic              cnt_en_i,
  input  logic              tick_i,
  output logic [TIME_W-1:0] time_o
);
  localparam logic [TIME_W-1:0] ERR_CODE = '1;
  localparam logic [TIME_W-1:0] SAT_VAL  = ERR_CODE - TIME_W'(1);

  logic [TIME_W-1:0] time_q, time_d;
  logic              inc, time_en;

  assign inc = cnt_en_i && tick_i && !freeze_i && (time_q < SAT_VAL);

  always_comb begin
    time_d = time_q;
    if (restart_i || arm_i) time_d = '0;
    else if (early_i)       time_d = ERR_CODE;
    else if (inc)           time_d = time_q + TIME_W'(1);
  end

  assign time_en = restart_i || arm_i || early_i || inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  assign time_o = time_q;

  // R4
  tick_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && tick_i && !freeze_i && !restart_i && time_q < SAT_VAL)
      |=> (time_q == $past(time_q) + TIME_W'(1)));
  // R4
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !tick_i && !restart_i) |=> $stable(time_q));
  // R5
  no_err_in_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |-> (time_q != ERR_CODE));
  // R6
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !arm_i && !early_i && !restart_i) |=> $stable(time_q));
  // R7
  early_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_i |=> (time_q == ERR_CODE));
  // R8
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (time_q == '0));
endmodule

// File: rtl/rxn_best.sv
module rxn_best #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              freeze_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] best_o
);
  localparam logic [TIME_W-1:0] EMPTY = '1;

  logic [TIME_W-1:0] best_q, best_d;
  logic              faster, best_en;

  assign faster = freeze_i && (time_i < best_q);

  always_comb begin
    best_d = best_q;
    if (clear_i)     best_d = EMPTY;
    else if (faster) best_d = time_i;
  end

  assign best_en = clear_i || faster;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      best_q <= EMPTY;
    else if (best_en) best_q <= best_d;
  end

  assign best_o = best_q;

  // R9
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (best_q == EMPTY));
  // R10
  never_rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (best_q <= $past(best_q)));
  // R10
  capture_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clear_i) |=> (best_q <= $past(time_i)));
  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && !clear_i) |=> $stable(best_q));
endmodule

// File: rtl/rxn_timer.sv
module rxn_timer
  import rxn_pkg::*;
#(
  parameter int unsigned WAIT_MS = 2000,
  parameter int unsigned TIME_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              start_ni,
  input  logic              react_ni,
  input  logic              restart_ni,
  input  logic              clear_ni,
  output logic              red_led_o,
  output logic              green_led_o,
  output logic [TIME_W-1:0] cur_time_o,
  output logic [TIME_W-1:0] best_time_o
);
  logic       rst_sync_n;
  logic       start_p, react_p, restart_p, clear_p;
  logic       arm, freeze, early;
  rxn_state_e state;

  assign start_p   = !start_ni;
  assign react_p   = !react_ni;
  assign restart_p = !restart_ni;
  assign clear_p   = !clear_ni;

  rxn_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  rxn_ctrl #(.WAIT_MS(WAIT_MS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (ms_tick_i),
    .start_i   (start_p),
    .react_i   (react_p),
    .restart_i (restart_p),
    .state_o   (state),
    .arm_o     (arm),
    .freeze_o  (freeze),
    .early_o   (early)
  );

  rxn_time #(.TIME_W(TIME_W)) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .restart_i (restart_p),
    .arm_i     (arm),
    .early_i   (early),
    .freeze_i  (freeze),
    .cnt_en_i  (state == ST_COUNT),
    .tick_i    (ms_tick_i),
    .time_o    (cur_time_o)
  );

  rxn_best #(.TIME_W(TIME_W)) u_best (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .clear_i  (clear_p),
    .freeze_i (freeze),
    .time_i   (cur_time_o),
    .best_o   (best_time_o)
  );

  assign red_led_o   = (state == ST_WAIT);
  assign green_led_o = (state == ST_COUNT);

  // R7
  early_leds_off_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    early |=> (!red_led_o && !green_led_o));
  // R3
  count_entry_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (red_led_o && !react_p && !restart_p) |=> (cur_time_o == '0));
endmodule

// File: tb/test_rxn_timer.sv
`timescale 1ns/1ps
module test_rxn_timer;
  localparam int unsigned WAIT_MS = 10;

  logic       clk = 1'b0;
  logic       rst_n, tick, start_n, react_n, restart_n, clear_n;
  logic       red, green;
  logic [7:0] cur, best;
  int         checks = 0;
  int         errors = 0;

  always #2 clk = ~clk;

  rxn_timer #(.WAIT_MS(WAIT_MS), .TIME_W(8)) i_rxn_timer (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .start_ni(start_n),
    .react_ni(react_n), .restart_ni(restart_n), .clear_ni(clear_n),
    .red_led_o(red), .green_led_o(green), .cur_time_o(cur), .best_time_o(best)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_leds(input string req, input logic r, input logic g);
    chk(req, "red", {7'd0, red}, {7'd0, r});
    chk(req, "green", {7'd0, green}, {7'd0, g});
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  task automatic press_start;
    start_n = 1'b0; cyc(); start_n = 1'b1;
  endtask

  task automatic press_react;
    react_n = 1'b0; cyc(); react_n = 1'b1;
  endtask

  task automatic run_to_count;
    press_start(); ticks(WAIT_MS);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; tick = 1'b0; start_n = 1'b1; react_n = 1'b1;
    restart_n = 1'b1; clear_n = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(3);
    chk_leds("R1", 1'b0, 1'b0);
    chk("R1", "cur", cur, 8'h00);
    chk("R1", "best", best, 8'hFF);
  endtask

  task automatic t_normal;
    press_start();
    chk_leds("R2", 1'b1, 1'b0);
    chk("R2", "cur", cur, 8'h00);
    ticks(WAIT_MS - 1);
    chk_leds("R3", 1'b1, 1'b0);
    cyc(3);
    chk_leds("R3", 1'b1, 1'b0);
    ticks(1);
    chk_leds("R3", 1'b0, 1'b1);
    chk("R3", "cur at entry", cur, 8'h00);
    ticks(5);
    chk("R4", "cur after 5 ticks", cur, 8'h05);
    cyc(2);
    chk("R4", "cur no tick", cur, 8'h05);
    react_n = 1'b0; tick = 1'b1; cyc(); react_n = 1'b1; tick = 1'b0;
    chk("R6", "cur frozen", cur, 8'h05);
    chk_leds("R6", 1'b0, 1'b0);
    chk("R10", "best first", best, 8'h05);
    ticks(4);
    chk("R6", "cur held", cur, 8'h05);
  endtask

  task automatic t_slower;
    run_to_count(); ticks(9); press_react();
    chk("R6", "cur slower", cur, 8'h09);
    chk("R10", "best kept on slower", best, 8'h05);
  endtask

  task automatic t_early;
    press_start(); ticks(3); press_react();
    chk("R7", "cur early", cur, 8'hFF);
    chk_leds("R7", 1'b0, 1'b0);
    ticks(WAIT_MS + 2);
    chk("R7", "cur stays err", cur, 8'hFF);
    chk_leds("R7", 1'b0, 1'b0);
    chk("R10", "best after early", best, 8'h05);
  endtask

  task automatic t_ignore;
    react_n = 1'b0; cyc(2); react_n = 1'b1;
    chk_leds("R11", 1'b0, 1'b0);
    chk("R11", "cur idle react", cur, 8'hFF);
    start_n = 1'b0; cyc();
    ticks(WAIT_MS);
    chk_leds("R11", 1'b0, 1'b1);
    ticks(2);
    chk("R11", "cur start held", cur, 8'h02);
    start_n = 1'b1;
    press_react();
    chk("R10", "best faster", best, 8'h02);
  endtask

  task automatic t_restart;
    run_to_count(); ticks(4);
    restart_n = 1'b0; react_n = 1'b0; cyc(); restart_n = 1'b1; react_n = 1'b1;
    chk("R8", "cur", cur, 8'h00);
    chk_leds("R8", 1'b0, 1'b0);
    chk("R8", "best untouched", best, 8'h02);
    press_start(); ticks(2);
    restart_n = 1'b0; cyc(); restart_n = 1'b1;
    chk_leds("R8", 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    clear_n = 1'b0; cyc(); clear_n = 1'b1;
    chk("R9", "best cleared", best, 8'hFF);
    run_to_count(); ticks(7);
    react_n = 1'b0; clear_n = 1'b0; cyc(); react_n = 1'b1; clear_n = 1'b1;
    chk("R9", "clear beats capture", best, 8'hFF);
    chk("R6", "cur 7", cur, 8'h07);
    run_to_count(); ticks(6); press_react();
    chk("R10", "best after clear", best, 8'h06);
  endtask

  task automatic t_sat;
    run_to_count(); ticks(300);
    chk("R5", "cur saturated", cur, 8'hFE);
    chk_leds("R5", 1'b0, 1'b1);
    press_react();
    chk("R5", "cur frozen sat", cur, 8'hFE);
    chk("R10", "best vs sat", best, 8'h06);
  endtask

  task automatic t_zero;
    run_to_count(); press_react();
    chk("R10", "cur zero", cur, 8'h00);
    chk("R10", "best zero", best, 8'h00);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_slower();
    t_early();
    t_ignore();
    t_restart();
    t_clear();
    t_sat();
    t_zero();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule